// File: doc/BRIEF.md
# Double-Buffered PWM Period Generator

This block produces a pulse-width-modulated waveform from a 16-bit up-counter. A free-running prescaler divides the input clock, and a 3-bit select chooses which of its taps makes the counter advance. A compare against the active period value returns the counter to 1, sets the output and emits a one-cycle period-match pulse. A second compare against the active width value clears the output partway through the cycle.

Software sees only the pending period and the pending width registers. The block copies both into hidden active registers when an output cycle finishes, or at once when the load strobe is raised. The counter value is always visible on an output port, and software has no way to write it. While the enable input is low, the counter rests at 1, the output is low and the prescaler is held cleared.

Top module: `pwm_period_gen`

## Requirements
- R1: `clk_sel` picks the counter step interval D in input clock cycles. Codes 0 through 6 give D = 2^(code+1), so 2, 4, 8, 16, 32, 64 and 128, and code 7 gives D = 512. The first counter step comes D cycles after `enable` rises.
- R2: While `enable` is low, and also during reset, `count` stays at 1, `pwm_out` and `period_match` are low, and the prescaler is cleared.
- R3: Each prescaler step that is not a period match raises `count` by one. A step from 0xFFFF wraps to 0x0000.
- R4: A step taken while `count` equals the active period sets `count` to 1 and sets `pwm_out`. On the next cycle `period_match` is high for exactly one cycle, so one period lasts P·D cycles.
- R5: A write to the pending period shows on `period_rdata` on the next cycle. The value becomes active only when the current output cycle ends.
- R6: A high on `load` copies both pending registers into the active registers at once, and the counter is left alone. If a write arrives in the same cycle, the copy uses the value held before that write, and the written value becomes active at the following cycle end.
- R7: An active period of 0 gives a cycle of 65536 steps. The counter passes through 0xFFFF and 0x0000 before the match.
- R8: An active period of 1 gives a match on every step. `count` stays at 1 and `pwm_out` holds one level.
- R9: A step taken while `count` equals the active width clears `pwm_out`, unless that step is also a period match. The output is high for min(W,P)·D cycles of each period. A width of 0 keeps it low for the whole period.
- R10: The width register has a pending copy and an active copy. It follows the same write, readback (`width_rdata`) and transfer rules as the period register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the time base when high |
| clk_sel | input | 3 | Prescaler tap select |
| wr_period | input | 1 | Write strobe for the pending period |
| period_wdata | input | 16 | Pending period write data |
| wr_width | input | 1 | Write strobe for the pending width |
| width_wdata | input | 16 | Pending width write data |
| load | input | 1 | Single-cycle strobe that forces the pending-to-active transfer |
| period_rdata | output | 16 | Pending period readback |
| width_rdata | output | 16 | Pending width readback |
| count | output | 16 | Counter value |
| pwm_out | output | 1 | PWM output |
| period_match | output | 1 | One-cycle pulse after each period match |

## Verification
The bench measures cycle counts between match pulses and output-high times. It sweeps every tap select, and it sweeps small periods against widths of zero, below, equal to and above the period. A wrong tap mask would show up as a wrong interval. An off-by-one in the restart-at-1 rule or in the width compare would shift every measured length by D. A width of 0 handled badly would leave a one-step glitch high.

The bench also covers the special periods. It drives a period of 0, where a design that matched at zero instead of after the wrap would finish in 1 step rather than 65536. It drives a period of 1, where a design that let the counter run past 1 would change the output level. A mid-cycle write, a load strobe, and a load that collides with a write are each timed. A design that lacked buffering, ignored load, or let the write win would produce a period of the wrong length.

// File: rtl/pwm_period_gen.sv
`timescale 1ns/1ps
module pwm_period_gen #(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [2:0]       clk_sel,
  input  logic             wr_period,
  input  logic [CNT_W-1:0] period_wdata,
  input  logic             wr_width,
  input  logic [CNT_W-1:0] width_wdata,
  input  logic             load,
  output logic [CNT_W-1:0] period_rdata,
  output logic [CNT_W-1:0] width_rdata,
  output logic [CNT_W-1:0] count,
  output logic             pwm_out,
  output logic             period_match
);
  localparam int PRE_W = 9;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [PRE_W-1:0] pre_q, tap_mask;
  logic [CNT_W-1:0] cnt_q, next_per_q, cur_per_q, next_wid_q, cur_wid_q;
  logic             out_q, match_q;
  logic             tick, per_hit, wid_hit, reload;

  always_comb begin
    if (clk_sel == 3'd7) tap_mask = '1;
    else                 tap_mask = ~({PRE_W{1'b1}} << (clk_sel + 3'd1));
  end

  assign tick    = enable && ((pre_q & tap_mask) == tap_mask);
  assign per_hit = (cnt_q == cur_per_q);
  assign wid_hit = (cnt_q == cur_wid_q);
  assign reload  = tick && per_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (!enable) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_per_q <= '0;
      next_wid_q <= '0;
    end else begin
      if (wr_period) next_per_q <= period_wdata;
      if (wr_width)  next_wid_q <= width_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_per_q <= '0;
      cur_wid_q <= '0;
    end else if (load || reload) begin
      cur_per_q <= next_per_q;
      cur_wid_q <= next_wid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= CNT_ONE;
    else if (!enable) cnt_q <= CNT_ONE;
    else if (tick)    cnt_q <= per_hit ? CNT_ONE : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              out_q <= 1'b0;
    else if (!enable)        out_q <= 1'b0;
    else if (reload)         out_q <= |next_wid_q;
    else if (tick && wid_hit) out_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= reload;
  end

  assign period_rdata = next_per_q;
  assign width_rdata  = next_wid_q;
  assign count        = cnt_q;
  assign pwm_out      = out_q;
  assign period_match = match_q;
endmodule

module pwm_period_gen_chk #(
  parameter int CNT_W = 16
)(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [CNT_W-1:0] count,
  input logic             pwm_out,
  input logic             period_match
);
  a_r2_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == CNT_W'(1) && !pwm_out && !period_match));

  a_r3_step_or_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && count != $past(count)) |->
      (count == CNT_W'($past(count) + 1'b1) || count == CNT_W'(1)));

  a_r4_match_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    period_match |-> count == CNT_W'(1));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    period_match |=> !period_match);
endmodule

bind pwm_period_gen pwm_period_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .count(count),
  .pwm_out(pwm_out), .period_match(period_match)
);

// File: tb/sim_pwm_period_gen.sv
`timescale 1ns/1ps
module sim_pwm_period_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic wr_period = 1'b0, wr_width = 1'b0, load = 1'b0;
  logic [15:0] period_wdata = '0, width_wdata = '0;
  logic [15:0] period_rdata, width_rdata, count;
  logic pwm_out, period_match;

  int checks = 0;
  int errors = 0;
  int n, len, high, maxc;

  always #2.5 clk = ~clk;

  pwm_period_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_sel(clk_sel),
    .wr_period(wr_period), .period_wdata(period_wdata),
    .wr_width(wr_width), .width_wdata(width_wdata), .load(load),
    .period_rdata(period_rdata), .width_rdata(width_rdata),
    .count(count), .pwm_out(pwm_out), .period_match(period_match)
  );

  function automatic int div_of(int sel);
    return (sel == 7) ? 512 : (2 << sel);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    wr_period = 1'b0; wr_width = 1'b0; load = 1'b0;
  endtask

  task automatic configure(int p, int w, int sel);
    step();
    enable = 1'b0; clk_sel = 3'(sel);
    wr_period = 1'b1; period_wdata = 16'(p);
    wr_width = 1'b1;  width_wdata = 16'(w);
    step();
    load = 1'b1;
    step();
  endtask

  task automatic wait_match();
    n = 0;
    while (!period_match) begin step(); n++; end
  endtask

  task automatic measure();
    len = 0; high = 0; maxc = 0;
    do begin
      if (pwm_out) high++;
      if (int'(count) > maxc) maxc = int'(count);
      len++;
      step();
    end while (!period_match);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset count", count, 1);
    check("R2 reset out", pwm_out, 0);
    check("R2 reset match", period_match, 0);
    rst_n = 1'b1;
    step();

    for (int sel = 0; sel < 8; sel++) begin
      configure(3, 1, sel);
      enable = 1'b1;
      n = 0;
      do begin step(); n++; end while (count == 16'd1);
      check("R1 first step delay", n, div_of(sel));
      while (!period_match) begin step(); n++; end
      check("R4 first match time", n, 3 * div_of(sel));
      check("R4 count restarts at 1", count, 1);
      measure();
      check("R1 period length", len, 3 * div_of(sel));
      check("R9 high time", high, div_of(sel));
    end

    for (int p = 2; p <= 6; p++) begin
      for (int w = 0; w <= p + 1; w++) begin
        configure(p, w, 0);
        enable = 1'b1;
        step();
        wait_match();
        measure();
        check("R4 period sweep length", len, 2 * p);
        check("R3 counter peak", maxc, p);
        check("R9 width sweep high", high, 2 * ((w == 0) ? 0 : ((w < p) ? w : p)));
      end
    end

    configure(1, 1, 1);
    enable = 1'b1;
    n = 0;
    do begin step(); n++; end while (!period_match);
    check("R8 first match", n, 4);
    begin
      int lows = 0, moved = 0, hits = 0;
      for (int i = 0; i < 40; i++) begin
        step();
        if (!pwm_out) lows++;
        if (count != 16'd1) moved++;
        if (period_match) hits++;
      end
      check("R8 output never low", lows, 0);
      check("R8 count stays 1", moved, 0);
      check("R8 match every step", hits, 10);
    end

    configure(4, 2, 0);
    enable = 1'b1;
    step();
    wait_match();
    wr_period = 1'b1; period_wdata = 16'd6;
    wr_width = 1'b1;  width_wdata = 16'd3;
    measure();
    check("R5 readback", period_rdata, 6);
    check("R10 readback", width_rdata, 3);
    check("R5 old period kept", len, 8);
    check("R10 old width kept", high, 4);
    measure();
    check("R5 new period", len, 12);
    check("R10 new width", high, 6);

    configure(7, 3, 2);
    enable = 1'b1;
    step();
    wait_match();
    wr_period = 1'b1; period_wdata = 16'd5;
    len = 0;
    step(); len++;
    wr_period = 1'b1; period_wdata = 16'd3; load = 1'b1;
    step(); len++;
    while (!period_match) begin step(); len++; end
    check("R6 load before write", len, 40);
    check("R6 readback", period_rdata, 3);
    measure();
    check("R6 written value next", len, 24);
    check("R6 width high", high, 24);

    enable = 1'b0;
    step();
    check("R2 disabled count", count, 1);
    check("R2 disabled out", pwm_out, 0);
    check("R2 disabled match", period_match, 0);
    enable = 1'b1;
    n = 0;
    do begin step(); n++; end while (count == 16'd1);
    check("R2 prescaler cleared", n, 8);

    configure(0, 16'h8000, 0);
    enable = 1'b1;
    begin
      int prev = 1;
      int saw_top = 0;
      n = 0;
      do begin
        prev = int'(count);
        step(); n++;
        if (count == 16'hFFFF) saw_top = 1;
      end while (!period_match);
      check("R7 period zero length", n, 65536 * 2);
      check("R3 wrap to zero", prev, 0);
      check("R3 reached top", saw_top, 1);
    end

    report();
  end
endmodule